// File: doc/BRIEF.md
# Timestamped Multi-Channel Receive Packetizer

This block sits where each receive channel leaves its DSP pipeline and enters the buffering stage. That boundary is the receive time reference. Each channel turns its stream of valid-qualified samples into fixed-length packets. A packet is one header word followed by `PKT_LEN` payload words. The header word holds the reading of a free-running time counter. That counter is also driven out so that the transmit side shares the same clock of record.

The timestamp is captured in the cycle when a packet's first sample is presented, not when the packet is read out. Each channel writes into a packet FIFO of its own, as soon as its words exist. Two channels that are configured alike and receive samples in the same cycles therefore produce packets with equal timestamps, however a downstream reader chooses to service the FIFOs.

When a packet is due to begin, the channel checks whether its FIFO can hold a whole packet. If not, the entire packet is discarded and a sticky overrun flag is raised for that channel. Sample counting continues, so packet boundaries stay aligned with the sample stream.

Top module: `rx_pkt_stamper`

## Requirements
- R1: `time_now` is 0 in the cycle after a reset edge, rises by exactly one per clock thereafter, and wraps modulo 2^TIME_W.
- R2: The first FIFO word of each packet is a header with `rd_last`=0. Its data is the value of `time_now`, zero-extended to SAMPLE_W, in the cycle where that packet's first sample had `smp_valid` high.
- R3: A header is followed by exactly PKT_LEN payload words, holding the samples in arrival order. `rd_last` is 1 on the final payload word and 0 on every other word.
- R4: The channels are independent. Reading or stalling one channel's FIFO changes neither the content nor the timing of another channel's words.
- R5: When two channels start packets in the same cycle, their headers hold identical timestamps.
- R6: A packet start is accepted only if the FIFO has at least PKT_LEN+1 free words in that cycle, counting occupancy before that cycle's read. Otherwise all words of that packet are dropped and `overrun` for that channel goes to 1. It stays 1 until reset. The next packet starts PKT_LEN valid samples later.
- R7: A synchronous `rst` clears the counter, every partially built packet, both FIFOs and the overrun flags. The first valid sample after reset starts a new packet.
- R8: Each FIFO read port is first-word-fall-through. `rd_valid` is high when a word is held, and `rd_data`/`rd_last` show the oldest word. A pop happens when `rd_en` and `rd_valid` are both high, and `rd_en` on an empty FIFO does nothing. A word written at a clock edge is readable from the next cycle.
- R9: Cycles with `smp_valid` low neither write a word nor advance the position within a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | NUM_CH | Per-channel sample strobe |
| smp_data | input | NUM_CH*SAMPLE_W | Per-channel sample, channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| time_now | output | TIME_W | Shared time counter |
| rd_en | input | NUM_CH | Per-channel FIFO pop request |
| rd_valid | output | NUM_CH | Per-channel FIFO holds a word |
| rd_data | output | NUM_CH*SAMPLE_W | Per-channel oldest FIFO word |
| rd_last | output | NUM_CH | Oldest word ends its packet |
| overrun | output | NUM_CH | Sticky per-channel packet drop flag |

## Verification
A sample presented in cycle t has its words appear at the read port in cycle t+1. That is one register stage, the FIFO write. A header reports the counter value of cycle t itself. A pop requested in cycle t shows the next word in cycle t+1, and `time_now` advances once per edge. The bench's reference model applies every input at the same rising edge as the design. It then compares all outputs at the following falling edge, so each expected value is checked in exactly the cycle it falls due.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

   // Per-packet fill mode chosen when the first sample of a packet arrives.
   typedef enum logic {
      FILL_KEEP = 1'b0,
      FILL_SKIP = 1'b1
   } fill_mode_e;

   // Number of FIFO words one packet occupies: header plus payload.
   function automatic int unsigned pkt_words(input int unsigned payload_len);
      return payload_len + 1;
   endfunction

endpackage

// File: rtl/rxp_time_base.sv
module rxp_time_base #(
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   output logic [TIME_W-1:0] time_o
);

   always_ff @(posedge clk) begin
      if (rst) time_o <= '0;
      else     time_o <= time_o + 1'b1;
   end

endmodule

// File: rtl/rxp_chan_framer.sv
module rxp_chan_framer
   import rxp_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 32,
   parameter int unsigned TIME_W   = 32,
   parameter int unsigned PKT_LEN  = 126
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                s_valid,
   input  logic [SAMPLE_W-1:0] s_data,
   input  logic [TIME_W-1:0]   time_i,
   input  logic                room_ok,
   output logic                wr0_en,
   output logic [SAMPLE_W:0]   wr0_word,
   output logic                wr1_en,
   output logic [SAMPLE_W:0]   wr1_word,
   output logic                ovr_o
);

   localparam int unsigned POS_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

   logic [POS_W-1:0]    pos_q;
   fill_mode_e          mode_q;
   logic                ovr_q;
   logic [SAMPLE_W-1:0] hdr_word;
   logic                at_start;
   logic                at_end;
   logic                keep;
   logic                take;

   // Header widening: pick the variant that matches the width ratio.
   generate
      if (TIME_W == SAMPLE_W) begin : g_hdr_same
         assign hdr_word = time_i;
      end else begin : g_hdr_wide
         assign hdr_word = {{(SAMPLE_W - TIME_W){1'b0}}, time_i};
      end
   endgenerate

   always_comb begin
      at_start = (pos_q == '0);
      at_end   = (pos_q == LAST_POS);
      keep     = at_start ? room_ok : (mode_q == FILL_KEEP);
      take     = s_valid && keep;
      wr0_en   = take;
      wr1_en   = take && at_start;
      wr0_word = at_start ? {1'b0, hdr_word} : {at_end, s_data};
      wr1_word = {at_end, s_data};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q  <= '0;
         mode_q <= FILL_KEEP;
         ovr_q  <= 1'b0;
      end else if (s_valid) begin
         pos_q <= at_end ? '0 : pos_q + 1'b1;
         if (at_start) begin
            mode_q <= room_ok ? FILL_KEEP : FILL_SKIP;
            if (!room_ok) ovr_q <= 1'b1;
         end
      end
   end

   assign ovr_o = ovr_q;

endmodule

// File: rtl/rxp_pkt_fifo.sv
module rxp_pkt_fifo #(
   parameter int unsigned DATA_W = 33,
   parameter int unsigned DEPTH  = 256
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr0_en,
   input  logic [DATA_W-1:0]              wr0_data,
   input  logic                           wr1_en,
   input  logic [DATA_W-1:0]              wr1_data,
   input  logic                           rd_en,
   output logic                           rd_valid,
   output logic [DATA_W-1:0]              rd_data,
   output logic [$clog2(DEPTH+1)-1:0]     level
);

   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned LVL_W = $clog2(DEPTH + 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr_q;
   logic [AW-1:0]     rptr_q;
   logic [LVL_W-1:0]  level_q;
   logic [1:0]        nwr;
   logic              pop;

   assign nwr = {1'b0, wr0_en} + {1'b0, wr1_en};
   assign pop = rd_en && (level_q != '0);

   always_ff @(posedge clk) begin
      if (wr0_en) mem[wptr_q] <= wr0_data;
      if (wr1_en) mem[wptr_q + AW'(1)] <= wr1_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         level_q <= '0;
      end else begin
         wptr_q  <= wptr_q + AW'(nwr);
         rptr_q  <= rptr_q + AW'(pop);
         level_q <= level_q + LVL_W'(nwr) - LVL_W'(pop);
      end
   end

   assign rd_valid = (level_q != '0);
   assign rd_data  = mem[rptr_q];
   assign level    = level_q;

endmodule

// File: rtl/rx_pkt_stamper.sv
module rx_pkt_stamper
   import rxp_pkg::*;
#(
   parameter int unsigned NUM_CH     = 2,
   parameter int unsigned SAMPLE_W   = 32,
   parameter int unsigned TIME_W     = 32,
   parameter int unsigned PKT_LEN    = 126,
   parameter int unsigned FIFO_DEPTH = 256
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_CH-1:0]            smp_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0]   smp_data,
   output logic [TIME_W-1:0]            time_now,
   input  logic [NUM_CH-1:0]            rd_en,
   output logic [NUM_CH-1:0]            rd_valid,
   output logic [NUM_CH*SAMPLE_W-1:0]   rd_data,
   output logic [NUM_CH-1:0]            rd_last,
   output logic [NUM_CH-1:0]            overrun
);

   localparam int unsigned WORD_W    = SAMPLE_W + 1;
   localparam int unsigned PKT_WORDS = pkt_words(PKT_LEN);
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1);
   localparam logic [LVL_W-1:0] MAX_START_LVL = LVL_W'(FIFO_DEPTH - PKT_WORDS);

   // Elaboration-time parameter checks.
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (PKT_LEN < 1) begin : g_bad_len
         $error("PKT_LEN must be at least 1");
      end
      if (TIME_W > SAMPLE_W) begin : g_bad_tw
         $error("TIME_W must not exceed SAMPLE_W");
      end
      if ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0 || FIFO_DEPTH < 2) begin : g_bad_pow
         $error("FIFO_DEPTH must be a power of two");
      end
      if (FIFO_DEPTH < PKT_WORDS) begin : g_bad_depth
         $error("FIFO_DEPTH must hold one whole packet");
      end
   endgenerate

   rxp_time_base #(.TIME_W(TIME_W)) u_time (
      .clk    (clk),
      .rst    (rst),
      .time_o (time_now)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic              wr0_en;
         logic [WORD_W-1:0] wr0_word;
         logic              wr1_en;
         logic [WORD_W-1:0] wr1_word;
         logic [LVL_W-1:0]  level;
         logic              room_ok;
         logic [WORD_W-1:0] head;

         assign room_ok = (level <= MAX_START_LVL);

         rxp_chan_framer #(
            .SAMPLE_W (SAMPLE_W),
            .TIME_W   (TIME_W),
            .PKT_LEN  (PKT_LEN)
         ) u_framer (
            .clk      (clk),
            .rst      (rst),
            .s_valid  (smp_valid[c]),
            .s_data   (smp_data[c*SAMPLE_W +: SAMPLE_W]),
            .time_i   (time_now),
            .room_ok  (room_ok),
            .wr0_en   (wr0_en),
            .wr0_word (wr0_word),
            .wr1_en   (wr1_en),
            .wr1_word (wr1_word),
            .ovr_o    (overrun[c])
         );

         rxp_pkt_fifo #(
            .DATA_W (WORD_W),
            .DEPTH  (FIFO_DEPTH)
         ) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .wr0_en   (wr0_en),
            .wr0_data (wr0_word),
            .wr1_en   (wr1_en),
            .wr1_data (wr1_word),
            .rd_en    (rd_en[c]),
            .rd_valid (rd_valid[c]),
            .rd_data  (head),
            .level    (level)
         );

         assign rd_data[c*SAMPLE_W +: SAMPLE_W] = head[SAMPLE_W-1:0];
         assign rd_last[c]                      = head[SAMPLE_W];
      end
   endgenerate

endmodule

// File: rtl/rx_pkt_stamper_chk.sv
module rx_pkt_stamper_chk #(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned SAMPLE_W = 32,
   parameter int unsigned TIME_W   = 32
) (
   input logic                       clk,
   input logic                       rst,
   input logic [TIME_W-1:0]          time_now,
   input logic [NUM_CH-1:0]          rd_en,
   input logic [NUM_CH-1:0]          rd_valid,
   input logic [NUM_CH*SAMPLE_W-1:0] rd_data,
   input logic [NUM_CH-1:0]          rd_last,
   input logic [NUM_CH-1:0]          overrun
);

   logic seen_rst = 1'b0;

   always_ff @(posedge clk) begin
      if (rst) seen_rst <= 1'b1;
   end

   AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
      (seen_rst && !$past(rst)) |-> (time_now == $past(time_now) + 1'b1)); // R1

   AST_RESET_CLEARS: assert property (@(posedge clk)
      (seen_rst && $past(rst)) |-> (rd_valid == '0 && overrun == '0 && time_now == '0)); // R7

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
         AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
            (seen_rst && overrun[c]) |=> overrun[c]); // R6

         AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
            (seen_rst && rd_valid[c] && !rd_en[c]) |=>
               (rd_valid[c] && $stable(rd_data[c*SAMPLE_W +: SAMPLE_W]) && $stable(rd_last[c]))); // R8
      end
   endgenerate

endmodule

bind rx_pkt_stamper rx_pkt_stamper_chk #(
   .NUM_CH   (NUM_CH),
   .SAMPLE_W (SAMPLE_W),
   .TIME_W   (TIME_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .time_now (time_now),
   .rd_en    (rd_en),
   .rd_valid (rd_valid),
   .rd_data  (rd_data),
   .rd_last  (rd_last),
   .overrun  (overrun)
);

// File: tb/rx_pkt_stamper_bench.sv
`timescale 1ns/1ps
module rx_pkt_stamper_bench;

   localparam int L = 4;
   localparam int D = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  smp_valid = '0;
   logic [63:0] smp_data  = '0;
   logic [31:0] time_now;
   logic [1:0]  rd_en = '0;
   logic [1:0]  rd_valid;
   logic [63:0] rd_data;
   logic [1:0]  rd_last;
   logic [1:0]  overrun;

   always #2 clk = ~clk;

   rx_pkt_stamper #(
      .NUM_CH(2), .SAMPLE_W(32), .TIME_W(32), .PKT_LEN(L), .FIFO_DEPTH(D)
   ) u_rx_pkt_stamper (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
      .time_now(time_now), .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_last(rd_last), .overrun(overrun)
   );

   // Reference model state: entry = {is_header, last, data}
   logic [33:0] mq [2][$];
   int          idx  [2];
   bit          skip [2];
   bit          movr [2];
   logic [31:0] mcnt;

   int    nchk = 0;
   int    nerr = 0;
   bit    chk_on = 0;
   bit    sync_on = 0;
   bit    done = 0;
   string tag_valid = "R8";
   string tag_data  = "R3";

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int old;
      if (rst) begin
         for (int c = 0; c < 2; c++) begin
            mq[c].delete();
            idx[c] = 0; skip[c] = 0; movr[c] = 0;
         end
         mcnt = '0;
      end else begin
         for (int c = 0; c < 2; c++) begin
            old = mq[c].size();
            if (smp_valid[c]) begin
               if (idx[c] == 0) begin
                  if (D - old >= L + 1) begin
                     skip[c] = 0;
                     mq[c].push_back({1'b1, 1'b0, mcnt});
                  end else begin
                     skip[c] = 1;
                     movr[c] = 1;
                  end
               end
               if (!skip[c]) mq[c].push_back({1'b0, (idx[c] == L - 1), smp_data[c*32 +: 32]});
               idx[c] = (idx[c] == L - 1) ? 0 : idx[c] + 1;
            end
            if (rd_en[c] && old > 0) void'(mq[c].pop_front());
         end
         mcnt = mcnt + 1;
      end
   end

   always @(negedge clk) begin
      if (chk_on && !done) begin
         check(time_now === mcnt, "R1", time_now, mcnt);
         for (int c = 0; c < 2; c++) begin
            bit ev;
            ev = mq[c].size() > 0;
            check(rd_valid[c] === ev, tag_valid, rd_valid[c], ev);
            if (ev && rd_valid[c]) begin
               logic [33:0] e;
               e = mq[c][0];
               check(rd_data[c*32 +: 32] === e[31:0], e[33] ? "R2" : tag_data, rd_data[c*32 +: 32], e[31:0]);
               check(rd_last[c] === e[32], "R3", rd_last[c], e[32]);
            end
            check(overrun[c] === movr[c], "R6", overrun[c], movr[c]);
         end
         if (sync_on && rd_valid == 2'b11)
            check(rd_data[31:0] === rd_data[63:32], "R5", rd_data[63:32], rd_data[31:0]);
      end
   end

   task automatic run(input int n, input int v0, input int v1, input int r0, input int r1, input bit same);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_valid[0] = ($urandom % 100) < v0;
         smp_valid[1] = ($urandom % 100) < v1;
         smp_data     = {$urandom, $urandom};
         rd_en[0]     = ($urandom % 100) < r0;
         rd_en[1]     = ($urandom % 100) < r1;
         if (same) begin
            smp_valid[1]    = smp_valid[0];
            smp_data[63:32] = smp_data[31:0];
            rd_en[1]        = rd_en[0];
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_on = 1;
      check(rd_valid === 2'b00 && overrun === 2'b00 && time_now === 32'd0, "R7",
            {rd_valid, overrun, time_now}, 0);
      rst = 0;
      // R5: identical channels started together
      sync_on = 1;
      run(40, 100, 100, 100, 100, 1);
      run(30, 60, 60, 40, 40, 1);
      sync_on = 0;
      // R4, R9: gaps and unequal read rates
      tag_valid = "R4"; tag_data = "R9";
      run(300, 55, 80, 70, 35, 0);
      tag_valid = "R8"; tag_data = "R3";
      run(30, 0, 0, 100, 100, 0);
      // R6: stall channel 1 reader, keep writing
      run(80, 100, 100, 100, 0, 0);
      run(40, 60, 60, 100, 100, 0);
      // R7: reset mid-packet
      run(2, 100, 100, 0, 0, 0);
      @(negedge clk);
      rst = 1;
      run(2, 100, 100, 100, 100, 0);
      @(negedge clk);
      smp_valid = '0;
      rd_en = '0;
      check(rd_valid === 2'b00 && overrun === 2'b00, "R7", {rd_valid, overrun}, 0);
      rst = 0;
      tag_data = "R7";
      run(60, 70, 70, 50, 50, 0);
      tag_data = "R3";
      run(50, 0, 0, 100, 100, 0);
      @(negedge clk);
      check(rd_valid === 2'b00, "R8", rd_valid, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++;
         nerr++;
         $display("FAIL watchdog: run hung, got no end, expected end");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule